// File: doc/BRIEF.md
# Radix-4 Booth Multiplier, 8 by 8, Registered

This block multiplies two 8-bit operands and returns a 16-bit product. It can treat the operands either as unsigned magnitudes or as two's-complement values. It uses radix-4 Booth recoding. The multiplier operand is zero-padded below its lowest bit and split into overlapping 3-bit windows. Each window is turned into a digit in {-2,-1,0,+1,+2}, carried as three control flags: one-times, two-times and invert. Each digit selects a row from the multiplicand. The row is inverted when the digit is negative, and a +1 is added at the row's lowest weight to complete the negation. A sign bit computed from the multiplicand's top bit and the window's top bit extends the row to full width. The rows are shifted by two places per digit and added.

One register stage captures the operands and the mode flag. A second register stage holds the sum. A pair presented before a rising edge therefore appears on the product port after the following rising edge. In unsigned mode the multiplier is zero-extended by two bits, which adds a fifth window. In signed mode only the four windows over the sign-extended operand take part.

Top module: `radix4_booth_mult`

## Requirements
- R1: With signed_mode low at capture, prod equals opa*opb taken as unsigned 8-bit numbers, as an exact 16-bit value.
- R2: With signed_mode high at capture, prod equals opa*opb taken as two's-complement 8-bit numbers, as a 16-bit two's-complement value (the result modulo 2^16).
- R3: Operands and mode sampled at rising edge k show on prod after rising edge k+1. prod does not change while the sampled inputs stay the same.
- R4: While rst is high at a rising edge, both register stages clear, so prod reads 0. After rst falls, prod still reads 0 after the first edge and shows the product of the inputs only after the second edge.
- R5: The window-to-flag mapping is as follows. 000 gives no flags. 001 and 010 give one-times. 011 gives two-times. 100 gives two-times with invert. 101 and 110 give one-times with invert. 111 gives invert alone. One-times and two-times are never set together.
- R6: A window whose invert flag is set with both magnitude flags clear (window 111) contributes exactly zero to the sum.
- R7: Each row's extension bit is the multiplicand's extended top bit XOR the window's top bit. It is forced to 0 for windows 000 and 111, and it always matches the sign of the inverted-or-plain row.
- R8: Corner pairs give the following products. 0xFF*0xFF gives 0xFE01 unsigned and 0x0001 signed. 0x80*0x80 gives 0x4000 in both modes. 0x80*0x7F gives 0xC080 signed.
- R9: The pair 0xBB*0x7B in unsigned mode (187*123) gives 0x59D9.
- R10: A change of signed_mode has an effect only through the capture register. prod keeps its value until the edge after the new mode is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset for both register stages |
| signed_mode | input | 1 | 1: two's-complement operands, 0: unsigned operands |
| opa | input | 8 | Multiplicand |
| opb | input | 8 | Multiplier operand, Booth-recoded |
| prod | output | 16 | Registered product |

## Verification
A fault in one Booth lane distorts the product, but only for multiplier values whose window at that lane position has the affected code. A single bad window code can therefore hide from sparse tests. Every operand pair is swept in both modes, and each product is compared two edges after its operands are driven. A bad window code, a missing negation carry or a wrong extension bit then shows as a mismatch on the very first pair that reaches that lane. A stuck capture register or a slipped latency shows on the first pair of the sweep.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Control flags produced for one recoded radix-4 digit
    typedef struct packed {
        logic one_x;    // select multiplicand
        logic two_x;    // select multiplicand shifted left once
        logic inv;      // digit is negative
    } bdigit_t;

endpackage

// File: rtl/booth_enc.sv
module booth_enc
    import booth_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] win,
    output bdigit_t    ctl
);

    always_comb begin
        ctl = '0;
        unique case (win)
            3'b000: ctl = '{one_x: 1'b0, two_x: 1'b0, inv: 1'b0};
            3'b001,
            3'b010: ctl = '{one_x: 1'b1, two_x: 1'b0, inv: 1'b0};
            3'b011: ctl = '{one_x: 1'b0, two_x: 1'b1, inv: 1'b0};
            3'b100: ctl = '{one_x: 1'b0, two_x: 1'b1, inv: 1'b1};
            3'b101,
            3'b110: ctl = '{one_x: 1'b1, two_x: 1'b0, inv: 1'b1};
            3'b111: ctl = '{one_x: 1'b0, two_x: 1'b0, inv: 1'b1};
            default: ctl = '0;
        endcase
    end

    // R5
    ctl_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.one_x, ctl.two_x}));

endmodule

// File: rtl/booth_row.sv
module booth_row
    import booth_pkg::*;
#(
    parameter int OPW   = 8,
    parameter int PW    = 2 * OPW,
    parameter int SHIFT = 0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW:0]   mcand_x,   // multiplicand extended by one bit
    input  logic [2:0]     win,
    input  bdigit_t        ctl,
    output logic [PW-1:0]  contrib
);

    localparam int RW = OPW + 2;

    logic [RW-1:0] sel;
    logic [RW-1:0] row;
    logic          active;
    logic          do_inv;
    logic          ext_bit;
    logic [PW-1:0] wide;

    always_comb begin
        if (ctl.two_x)      sel = {mcand_x, 1'b0};
        else if (ctl.one_x) sel = {mcand_x[OPW], mcand_x};
        else                sel = '0;

        active  = ctl.one_x | ctl.two_x;
        do_inv  = ctl.inv & active;
        row     = do_inv ? ~sel : sel;

        if (win == 3'b000 || win == 3'b111) ext_bit = 1'b0;
        else                                ext_bit = mcand_x[OPW] ^ win[2];

        wide    = {{(PW-RW){ext_bit}}, row};
        contrib = (wide << SHIFT) + (PW'(do_inv) << SHIFT);
    end

    // R7
    e_sign_chk: assert property (@(posedge clk) disable iff (rst)
        ext_bit == row[RW-1]);

    // R6
    neg_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.inv && !ctl.one_x && !ctl.two_x) |-> (contrib == '0));

endmodule

// File: rtl/radix4_booth_mult.sv
module radix4_booth_mult
    import booth_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             signed_mode,
    input  logic [OPW-1:0]   opa,
    input  logic [OPW-1:0]   opb,
    output logic [2*OPW-1:0] prod
);

    localparam int PW   = 2 * OPW;
    localparam int NROW = OPW / 2 + 1;
    localparam int BXW  = OPW + 2;

    typedef struct packed {
        logic           mode;
        logic [OPW-1:0] a;
        logic [OPW-1:0] b;
        logic [PW-1:0]  prod;
    } state_t;

    state_t st_d, st_q;

    logic [BXW-1:0] b_ext;
    logic [BXW:0]   b_pad;
    logic [OPW:0]   mcand_x;
    logic [PW-1:0]  contrib [NROW];

    assign b_ext   = st_q.mode ? {{2{st_q.b[OPW-1]}}, st_q.b} : {2'b00, st_q.b};
    assign b_pad   = {b_ext, 1'b0};
    assign mcand_x = {st_q.mode & st_q.a[OPW-1], st_q.a};

    for (genvar j = 0; j < NROW; j++) begin : g_lane
        localparam bit LAST = (j == NROW - 1);
        logic [2:0] win_raw;
        logic [2:0] win_g;
        bdigit_t    ctl;

        assign win_raw = b_pad[2*j+2 -: 3];
        if (LAST) begin : g_top
            assign win_g = st_q.mode ? 3'b000 : win_raw;
        end else begin : g_mid
            assign win_g = win_raw;
        end

        booth_enc u_enc (
            .clk (clk),
            .rst (rst),
            .win (win_g),
            .ctl (ctl)
        );

        booth_row #(.OPW(OPW), .PW(PW), .SHIFT(2*j)) u_row (
            .clk     (clk),
            .rst     (rst),
            .mcand_x (mcand_x),
            .win     (win_g),
            .ctl     (ctl),
            .contrib (contrib[j])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.mode = signed_mode;
        st_d.a    = opa;
        st_d.b    = opb;
        st_d.prod = '0;
        for (int j = 0; j < NROW; j++) begin
            st_d.prod = st_d.prod + contrib[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign prod = st_q.prod;

    // R4
    reset_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (prod == '0));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(st_q.a) && $stable(st_q.b) && $stable(st_q.mode)) |=> $stable(prod));

endmodule

// File: tb/radix4_booth_mult_tb_top.sv
`timescale 1ns/1ps
module radix4_booth_mult_tb_top;

    localparam real HALF = 10.0;
    localparam int  NV   = 11;

    // {mode, a, b, expected}
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 8'hBB, 8'h7B, 16'h59D9},   // R9
        {1'b0, 8'hFF, 8'hFF, 16'hFE01},   // R8
        {1'b1, 8'hFF, 8'hFF, 16'h0001},   // R8 R6
        {1'b0, 8'h80, 8'h80, 16'h4000},   // R8
        {1'b1, 8'h80, 8'h80, 16'h4000},   // R8
        {1'b1, 8'h80, 8'h7F, 16'hC080},   // R8
        {1'b1, 8'h7F, 8'h7F, 16'h3F01},   // R2
        {1'b0, 8'h00, 8'hFF, 16'h0000},   // R1
        {1'b1, 8'h00, 8'hFF, 16'h0000},   // R7
        {1'b0, 8'h01, 8'hAA, 16'h00AA},   // R5
        {1'b1, 8'hF1, 8'h67, 16'hF9F7}    // R2
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        signed_mode = 1'b0;
    logic [7:0]  opa = '0;
    logic [7:0]  opb = '0;
    logic [15:0] prod;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(HALF) clk = ~clk;

    radix4_booth_mult dut_i (
        .clk         (clk),
        .rst         (rst),
        .signed_mode (signed_mode),
        .opa         (opa),
        .opb         (opb),
        .prod        (prod)
    );

    function automatic logic [15:0] ref_mul(input logic m, input logic [7:0] a, input logic [7:0] b);
        int sa, sb, p;
        sa = m ? int'($signed(a)) : int'(a);
        sb = m ? int'($signed(b)) : int'(b);
        p  = sa * sb;
        return p[15:0];
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: prod=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic m, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        signed_mode = m;
        opa = a;
        opb = b;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] hist0, hist1;

        // R4: reset clears output even with live inputs
        opa = 8'h5A; opb = 8'hC3; signed_mode = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R4 in reset", prod, 16'h0000);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R4 first edge after reset", prod, 16'h0000);
        @(posedge clk);
        @(negedge clk);
        check("R3 second edge after reset", prod, ref_mul(1'b0, 8'h5A, 8'hC3));
        @(posedge clk);
        @(negedge clk);
        check("R3 held inputs keep product", prod, ref_mul(1'b0, 8'h5A, 8'hC3));

        // R10: mode flip is not seen until captured and registered
        opa = 8'hF0; opb = 8'h90; signed_mode = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R1 unsigned F0*90", prod, 16'h8700);
        signed_mode = 1'b1;
        #1;
        check("R10 before capture", prod, 16'h8700);
        @(posedge clk); @(negedge clk);
        check("R10 after capture only", prod, 16'h8700);
        @(posedge clk); @(negedge clk);
        check("R10 signed F0*90", prod, 16'h0700);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][32], VEC[i][31:24], VEC[i][23:16]);
            check("R1/R2 table vector", prod, VEC[i][15:0]);
        end

        // Exhaustive streamed sweep: unsigned (R1) then signed (R2);
        // every window code of R5 reaches every lane
        hist0 = '0; hist1 = '0;
        for (int k = 0; k < 131072 + 2; k++) begin
            @(negedge clk);
            if (k >= 2) check(k < 65538 ? "R1 sweep" : "R2 sweep", prod, hist1);
            hist1 = hist0;
            if (k < 131072) begin
                signed_mode = k[16];
                opa = k[15:8];
                opb = k[7:0];
                hist0 = ref_mul(k[16], k[15:8], k[7:0]);
            end
        end

        // R4: reset mid-stream clears the product
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R4 reset mid-stream", prod, 16'h0000);
        rst = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: prod=%h expected=completion", prod);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule